// File: doc/BRIEF.md
# Throttled Burst Stride Prefetcher

This block sits beside one processor's private data cache and watches its stream of load misses, each given as the program counter of the missing load and the missed byte address. A fully associative table keyed by program counter remembers, for each load, the address of its previous miss, the distance between its last two misses and a confidence level. When a load misses twice in a row at the same non-zero distance, the table considers the stride confirmed and starts a burst of prefetch requests toward the shared second-level cache.

A burst is sixteen requests by default, at one, two and up to sixteen strides ahead of the miss that confirmed the stride. Requests leave through a valid/ready port and are paced by a throttle, so that at least a set number of cycles separates two accepted requests. Every request carries a tag telling the second-level cache to drop it on a miss rather than fetch from memory. A newer burst takes over from an unfinished one, but never withdraws a request that is already being offered.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `pf_valid` is low, and no program counter is known to the table, so no burst can start before a load has missed three times after reset.
- R2: The first miss of an unknown program counter allocates an entry in the initial state (code 0); its second miss stores the distance and moves it to the transient state (code 1); a third miss at the same non-zero distance moves it to the steady state (code 2) and starts a burst.
- R3: A miss whose distance differs from the stored one, or is zero, puts the entry in the transient state with the new distance and starts no burst.
- R4: A burst consists of exactly BURST_LEN requests whose addresses are the confirming miss address plus k times the stride, for k = 1 to BURST_LEN in increasing order, modulo 2^AW; a negative stride is the two's complement distance.
- R5: A miss that hits a steady entry at the stored distance starts a fresh burst counted from this new miss address.
- R6: Two accepted requests are at least GAP cycles apart; when the throttle is idle, the first request of a burst is offered in the cycle after the confirming miss.
- R7: `pf_l2_only` is high with every offered request.
- R8: Once `pf_valid` is high it stays high with the same `pf_addr` until `pf_ready` is sampled high.
- R9: A burst started while a request is offered and not accepted waits until that request is accepted, then replaces the rest of the old burst; among several waiting bursts the most recent one wins.
- R10: With the table full, a miss from a new program counter replaces the entry whose last miss is the oldest; misses that hit refresh an entry's recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | A data-cache load miss is reported this cycle |
| miss_pc | input | PCW | Program counter of the missing load |
| miss_addr | input | AW | Byte address of the miss |
| pf_ready | input | 1 | The second-level cache takes the offered request |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | AW | Address of the offered request |
| pf_l2_only | output | 1 | Request must not go beyond the second-level cache |

## Verification
Positive, negative and zero strides are each trained on their own program counter: the first two separate an address generator that counts correctly in both directions from one that only adds, and the zero stride shows that an unchanging address never confirms. A stride that changes before it repeats tells the transient state apart from a two-miss confirmation. A table with four entries fed five program counters in a chosen order shows whether the victim is the least recently missed load rather than the oldest allocation. Holding `pf_ready` low while a second burst is confirmed separates waiting until acceptance from dropping or replacing the offered request, and a long stretch of random misses with random backpressure compares every cycle against a model kept in the bench.

// File: rtl/stp_pkg.sv
package stp_pkg;

    // Confidence levels of one table entry.
    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_TRANS  = 2'd1,
        ST_STEADY = 2'd2
    } conf_e;

    // Outcome of training an entry with one new distance.
    typedef struct packed {
        conf_e nxt;
        logic  fire;
    } train_t;

    // A fresh distance confirms the stride only when it repeats the stored
    // one, is non-zero and the entry has already seen one distance.
    function automatic train_t stp_train(conf_e cur, logic same, logic nonzero);
        train_t r;
        r.nxt  = ST_TRANS;
        r.fire = 1'b0;
        if (cur != ST_INIT && same && nonzero) begin
            r.nxt  = ST_STEADY;
            r.fire = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/stp_table.sv
module stp_table
    import stp_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PCW   = 32,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          miss_valid,
    input  logic [PCW-1:0] miss_pc,
    input  logic [AW-1:0] miss_addr,
    output logic          fire,
    output logic [AW-1:0] fire_base,
    output logic [AW-1:0] fire_stride
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic           vld;
        logic [PCW-1:0] pc;
        logic [AW-1:0]  last;
        logic [AW-1:0]  stride;
        conf_e          st;
    } entry_t;

    entry_t          ent_q [DEPTH];
    logic [IW-1:0]   age_q [DEPTH];   // 0 = most recent, DEPTH-1 = victim

    logic [DEPTH-1:0] hit_vec;
    logic             hit;
    logic [IW-1:0]    hit_idx, vict_idx, sel;
    entry_t           sel_e;
    logic [IW-1:0]    sel_age;
    logic [AW-1:0]    delta;
    train_t           tr;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign hit_vec[g] = ent_q[g].vld && (ent_q[g].pc == miss_pc);
    end

    always_comb begin
        hit_idx  = '0;
        vict_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i])                   hit_idx  = IW'(i);
            if (age_q[i] == IW'(DEPTH - 1))   vict_idx = IW'(i);
        end
    end

    assign hit     = |hit_vec;
    assign sel     = hit ? hit_idx : vict_idx;
    assign sel_e   = ent_q[sel];
    assign sel_age = age_q[sel];
    assign delta   = miss_addr - sel_e.last;
    assign tr      = stp_train(sel_e.st, delta == sel_e.stride, delta != '0);

    assign fire        = miss_valid && hit && tr.fire;
    assign fire_base   = miss_addr;
    assign fire_stride = delta;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
                age_q[i] <= IW'(i);
            end
        end else if (miss_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IW'(i) == sel)          age_q[i] <= '0;
                else if (age_q[i] < sel_age) age_q[i] <= age_q[i] + 1'b1;
            end
            if (hit) begin
                ent_q[sel].last   <= miss_addr;
                ent_q[sel].stride <= delta;
                ent_q[sel].st     <= tr.nxt;
            end else begin
                ent_q[sel].vld    <= 1'b1;
                ent_q[sel].pc     <= miss_pc;
                ent_q[sel].last   <= miss_addr;
                ent_q[sel].stride <= '0;
                ent_q[sel].st     <= ST_INIT;
            end
        end
    end

endmodule

// File: rtl/stp_burst.sv
module stp_burst #(
    parameter int AW        = 32,
    parameter int BURST_LEN = 16,
    parameter int GAP       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [AW-1:0] fire_base,
    input  logic [AW-1:0] fire_stride,
    input  logic          pf_ready,
    output logic          pf_valid,
    output logic [AW-1:0] pf_addr
);
    localparam int CW = $clog2(BURST_LEN + 1);
    localparam int TW = (GAP > 1) ? $clog2(GAP) : 1;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] stride;
    } burst_t;

    logic          active_q;
    logic [AW-1:0] addr_q, stride_q;
    logic [CW-1:0] left_q;
    logic          pend_q;
    burst_t        pend_d_q;
    logic [TW-1:0] cool_q;

    logic accept, can_switch;

    assign pf_valid   = active_q && (cool_q == '0);
    assign pf_addr    = addr_q;
    assign accept     = pf_valid && pf_ready;
    assign can_switch = !pf_valid || pf_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            addr_q   <= '0;
            stride_q <= '0;
            left_q   <= '0;
            pend_q   <= 1'b0;
            pend_d_q <= '0;
            cool_q   <= '0;
        end else begin
            if (accept)             cool_q <= TW'(GAP - 1);
            else if (cool_q != '0)  cool_q <= cool_q - 1'b1;

            if (fire && can_switch) begin
                active_q <= 1'b1;
                addr_q   <= fire_base + fire_stride;
                stride_q <= fire_stride;
                left_q   <= CW'(BURST_LEN);
                pend_q   <= 1'b0;
            end else if (fire) begin
                pend_q   <= 1'b1;
                pend_d_q <= '{base: fire_base, stride: fire_stride};
            end else if (pend_q && can_switch) begin
                active_q <= 1'b1;
                addr_q   <= pend_d_q.base + pend_d_q.stride;
                stride_q <= pend_d_q.stride;
                left_q   <= CW'(BURST_LEN);
                pend_q   <= 1'b0;
            end else if (accept) begin
                addr_q <= addr_q + stride_q;
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) active_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
    parameter int DEPTH     = 512,
    parameter int PCW       = 32,
    parameter int AW        = 32,
    parameter int BURST_LEN = 16,
    parameter int GAP       = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           miss_valid,
    input  logic [PCW-1:0] miss_pc,
    input  logic [AW-1:0]  miss_addr,
    input  logic           pf_ready,
    output logic           pf_valid,
    output logic [AW-1:0]  pf_addr,
    output logic           pf_l2_only
);
    logic          fire;
    logic [AW-1:0] fire_base, fire_stride;

    stp_table #(.DEPTH(DEPTH), .PCW(PCW), .AW(AW)) u_table (
        .clk         (clk),
        .rst         (rst),
        .miss_valid  (miss_valid),
        .miss_pc     (miss_pc),
        .miss_addr   (miss_addr),
        .fire        (fire),
        .fire_base   (fire_base),
        .fire_stride (fire_stride)
    );

    stp_burst #(.AW(AW), .BURST_LEN(BURST_LEN), .GAP(GAP)) u_burst (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .fire_base   (fire_base),
        .fire_stride (fire_stride),
        .pf_ready    (pf_ready),
        .pf_valid    (pf_valid),
        .pf_addr     (pf_addr)
    );

    // Every request is marked to stop at the second-level cache.
    assign pf_l2_only = pf_valid;

endmodule

// File: rtl/stp_checker.sv
module stp_checker #(
    parameter int AW  = 32,
    parameter int GAP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          pf_valid,
    input logic          pf_ready,
    input logic [AW-1:0] pf_addr
);
    logic [31:0] since_q;
    logic        accept;

    assign accept = pf_valid && pf_ready;

    always_ff @(posedge clk) begin
        if (rst)                      since_q <= 32'(GAP);
        else if (accept)              since_q <= 32'd1;
        else if (since_q < 32'(GAP))  since_q <= since_q + 32'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !pf_valid);

    // R8
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid && !pf_ready |=> pf_valid);

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        pf_valid && !pf_ready |=> $stable(pf_addr));

    // R6
    throttle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> since_q >= 32'(GAP));

endmodule

bind stride_prefetcher stp_checker #(.AW(AW), .GAP(GAP)) u_stp_chk (
    .clk      (clk),
    .rst      (rst),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_addr  (pf_addr)
);

// File: tb/tb_stride_prefetcher.sv
module tb_stride_prefetcher;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int PCW        = 32;
    localparam int AW         = 32;
    localparam int BURST_LEN  = 16;
    localparam int GAP        = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_valid = 1'b0;
    logic [31:0]   miss_pc = '0;
    logic [31:0]   miss_addr = '0;
    logic          pf_ready = 1'b1;
    logic          pf_valid;
    logic [31:0]   pf_addr;
    logic          pf_l2_only;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stride_prefetcher #(.DEPTH(DEPTH), .PCW(PCW), .AW(AW),
                        .BURST_LEN(BURST_LEN), .GAP(GAP)) dut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_pc(miss_pc),
        .miss_addr(miss_addr), .pf_ready(pf_ready), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .pf_l2_only(pf_l2_only)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] t_pc [DEPTH];
    logic [31:0] t_last [DEPTH];
    logic [31:0] t_stride [DEPTH];
    int          t_st [DEPTH];
    bit          t_v [DEPTH];
    longint      t_stamp [DEPTH];
    longint      tick;

    bit          m_act;
    logic [31:0] m_addr, m_stride;
    int          m_left, m_cool;
    bit          m_pend;
    logic [31:0] m_pbase, m_pstride;
    logic [31:0] acc_q [$];
    longint      cyc, last_acc;
    bit          seen_acc;

    function automatic bit m_valid();
        return m_act && (m_cool == 0);
    endfunction

    always @(posedge clk) begin
        bit mv, acc, sw, fire;
        logic [31:0] fbase, fstride;
        cyc++;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                t_v[i] = 0; t_st[i] = 0; t_stride[i] = '0; t_last[i] = '0; t_pc[i] = '0;
                t_stamp[i] = i - DEPTH;
            end
            tick = 0; m_act = 0; m_left = 0; m_cool = 0; m_pend = 0;
            m_addr = '0; m_stride = '0; seen_acc = 0;
        end else begin
            mv = m_valid();
            acc = mv && pf_ready;
            sw = !mv || pf_ready;
            fire = 0; fbase = '0; fstride = '0;
            if (miss_valid) begin
                int h;
                h = -1;
                for (int i = 0; i < DEPTH; i++) if (t_v[i] && t_pc[i] == miss_pc) h = i;
                tick++;
                if (h >= 0) begin
                    logic [31:0] d;
                    d = miss_addr - t_last[h];
                    if (t_st[h] != 0 && d == t_stride[h] && d != 0) begin
                        t_st[h] = 2; fire = 1; fbase = miss_addr; fstride = d;
                    end else t_st[h] = 1;
                    t_stride[h] = d; t_last[h] = miss_addr; t_stamp[h] = tick;
                end else begin
                    int vi;
                    vi = 0;
                    for (int i = 1; i < DEPTH; i++) if (t_stamp[i] < t_stamp[vi]) vi = i;
                    t_v[vi] = 1; t_pc[vi] = miss_pc; t_last[vi] = miss_addr;
                    t_stride[vi] = '0; t_st[vi] = 0; t_stamp[vi] = tick;
                end
            end
            if (acc) begin
                acc_q.push_back(m_addr);
                if (seen_acc) chk(cyc - last_acc >= GAP, "R6 accept spacing",
                                  32'(cyc - last_acc), 32'(GAP));
                seen_acc = 1; last_acc = cyc;
            end
            if (acc) m_cool = GAP - 1; else if (m_cool > 0) m_cool--;
            if (fire && sw) begin
                m_act = 1; m_addr = fbase + fstride; m_stride = fstride;
                m_left = BURST_LEN; m_pend = 0;
            end else if (fire) begin
                m_pend = 1; m_pbase = fbase; m_pstride = fstride;
            end else if (m_pend && sw) begin
                m_act = 1; m_addr = m_pbase + m_pstride; m_stride = m_pstride;
                m_left = BURST_LEN; m_pend = 0;
            end else if (acc) begin
                m_addr = m_addr + m_stride; m_left--;
                if (m_left == 0) m_act = 0;
            end
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(pf_valid == m_valid(), "R4/R9 pf_valid vs model", 32'(pf_valid), 32'(m_valid()));
            if (m_valid()) chk(pf_addr == m_addr, "R4/R9 pf_addr vs model", pf_addr, m_addr);
            if (pf_valid) chk(pf_l2_only == 1'b1, "R7 l2-only tag", 32'(pf_l2_only), 32'd1);
        end
    end

    // ---------------- stimulus ----------------
    task automatic miss(logic [31:0] pc, logic [31:0] addr);
        @(negedge clk);
        miss_valid = 1'b1; miss_pc = pc; miss_addr = addr;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(pf_valid == 1'b0, "R1 valid low after reset", 32'(pf_valid), 32'd0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] cur [6];
        logic [31:0] strd [6];
        logic [31:0] choices [5];
        choices[0] = 32'd64; choices[1] = -32'sd16; choices[2] = 32'd8;
        choices[3] = 32'd4096; choices[4] = 32'd0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(pf_valid == 1'b0, "R1 valid low after reset", 32'(pf_valid), 32'd0);

        // R2 / R4: positive stride confirmation
        acc_q.delete();
        miss(32'hA0, 32'h1000);
        miss(32'hA0, 32'h1040);
        idle(10);
        chk(acc_q.size() == 0, "R2 no burst after two misses", 32'(acc_q.size()), 0);
        miss(32'hA0, 32'h1080);
        idle(80);
        chk(acc_q.size() == BURST_LEN, "R4 burst length", 32'(acc_q.size()), 32'(BURST_LEN));
        chk(acc_q[0] == 32'h10C0, "R4 first burst address", acc_q[0], 32'h10C0);
        chk(acc_q[15] == 32'h1480, "R4 last burst address", acc_q[15], 32'h1480);

        // R3: changing distance stays transient, then confirms
        acc_q.delete();
        miss(32'hB0, 32'h2000);
        miss(32'hB0, 32'h2010);
        miss(32'hB0, 32'h2030);
        idle(10);
        chk(acc_q.size() == 0, "R3 mismatch gives no burst", 32'(acc_q.size()), 0);
        miss(32'hB0, 32'h2050);
        idle(80);
        chk(acc_q.size() == BURST_LEN, "R3 confirm after mismatch", 32'(acc_q.size()), 32'(BURST_LEN));
        chk(acc_q[0] == 32'h2070, "R3 first address", acc_q[0], 32'h2070);

        // R3: zero distance never confirms
        acc_q.delete();
        repeat (4) miss(32'hC0, 32'h3000);
        idle(10);
        chk(acc_q.size() == 0, "R3 zero stride no burst", 32'(acc_q.size()), 0);

        // R4: negative stride
        acc_q.delete();
        miss(32'hD0, 32'h4000);
        miss(32'hD0, 32'h3FE0);
        miss(32'hD0, 32'h3FC0);
        idle(80);
        chk(acc_q.size() == BURST_LEN, "R4 negative burst length", 32'(acc_q.size()), 32'(BURST_LEN));
        chk(acc_q[0] == 32'h3FA0, "R4 negative first", acc_q[0], 32'h3FA0);
        chk(acc_q[15] == 32'h3DC0, "R4 negative last", acc_q[15], 32'h3DC0);

        // R5: steady hits restart the burst from the newest miss
        acc_q.delete();
        miss(32'hA0, 32'h10C0);
        idle(10);
        miss(32'hA0, 32'h1100);
        idle(90);
        chk(acc_q.size() > 0 && acc_q[acc_q.size()-1] == 32'h1500, "R5 restarted burst end",
            acc_q.size() > 0 ? acc_q[acc_q.size()-1] : 32'h0, 32'h1500);

        // R10 (and R1 table cleared): LRU replacement in a 4-entry table
        do_reset();
        acc_q.delete();
        miss(32'h51, 32'h5000);
        miss(32'h52, 32'h6000);
        miss(32'h53, 32'h7000);
        miss(32'h54, 32'h7800);
        miss(32'h51, 32'h5100);
        miss(32'h55, 32'hA000);
        miss(32'h51, 32'h5200);
        idle(80);
        chk(acc_q.size() == BURST_LEN, "R10 refreshed entry kept", 32'(acc_q.size()), 32'(BURST_LEN));
        chk(acc_q[0] == 32'h5300, "R10 refreshed entry burst", acc_q[0], 32'h5300);
        acc_q.delete();
        miss(32'h52, 32'h6040);
        miss(32'h52, 32'h6080);
        idle(10);
        chk(acc_q.size() == 0, "R10 LRU entry was evicted", 32'(acc_q.size()), 0);

        // R8 / R9: backpressure and preemption
        acc_q.delete();
        pf_ready = 1'b0;
        miss(32'hE1, 32'h8000);
        miss(32'hE1, 32'h8008);
        miss(32'hE1, 32'h8010);
        idle(5);
        chk(pf_valid == 1'b1 && pf_addr == 32'h8018, "R8 offer held", pf_addr, 32'h8018);
        miss(32'hE2, 32'h9000);
        miss(32'hE2, 32'h9020);
        miss(32'hE2, 32'h9040);
        idle(3);
        chk(pf_valid == 1'b1 && pf_addr == 32'h8018, "R8 offer kept under new burst", pf_addr, 32'h8018);
        pf_ready = 1'b1;
        idle(90);
        chk(acc_q.size() == BURST_LEN + 1, "R9 one old plus new burst", 32'(acc_q.size()), 32'(BURST_LEN + 1));
        chk(acc_q[0] == 32'h8018, "R9 old request delivered", acc_q[0], 32'h8018);
        chk(acc_q[1] == 32'h9060, "R9 new burst takes over", acc_q[1], 32'h9060);

        // Random misses and backpressure, compared with the model every cycle.
        for (int p = 0; p < 6; p++) begin
            cur[p] = 32'h10000 * (p + 1);
            strd[p] = choices[p % 5];
        end
        for (int n = 0; n < 3000; n++) begin
            int p;
            @(negedge clk);
            pf_ready = ($urandom % 4) != 0;
            p = $urandom % 6;
            if (($urandom % 3) == 0) begin
                if (($urandom % 8) == 0) strd[p] = choices[$urandom % 5];
                cur[p] = cur[p] + strd[p];
                miss_valid = 1'b1; miss_pc = 32'h100 + p; miss_addr = cur[p];
            end else begin
                miss_valid = 1'b0;
            end
        end
        @(negedge clk);
        miss_valid = 1'b0;
        pf_ready = 1'b1;
        idle(80);
        finish_run();
    end

endmodule